// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time

This block is a single timer channel that drives a complementary pair of PWM pins. An up-counter runs from zero to a programmable period and then wraps. It is compared against a programmable compare value to form an internal active-high reference waveform. That reference feeds two paths. The direct path drives the main pin and the inverted path drives the complementary pin. Each turn-on edge is delayed by a programmable number of clock cycles, so the two pins are never active at the same time. Each pin has its own polarity bit and its own enable. A shared off-state bit decides what a disabled pin does: it either floats (output-enable low) or is driven to its inactive level.

Software can also force the reference high or low through a mode field. The counter and the compare-match indication keep running while the reference is forced. Because forcing acts on the reference, both pins move together and stay opposite to each other. When only one pin of the pair is enabled, that pin carries the reference without inversion and without dead time. So clearing the main enable turns the complementary pin into a non-inverted copy of the reference, and its polarity bit must be flipped to restore the earlier waveform. All configuration goes through a write-enable, address and data port.

Top module: `cpwm_channel`

## Requirements
- R1: While control bit 5 (run) is 1, the counter advances by one per clock. In the clock after it holds a value at or above the period register, it returns to 0. While run is 0, the counter holds its value.
- R2: With mode 3'b110, `oc_ref` is 1 exactly when the counter value is below the compare value, in the same cycle as that counter value. A compare value of 0 gives a constant 0. A compare value above the period gives a constant 1.
- R3: Mode 3'b101 holds `oc_ref` at 1. Mode 3'b100 holds it at 0. Every other mode code except 3'b110 also holds it at 0.
- R4: `cmp_match` is 1 exactly when the counter equals the compare value, in every mode, forced modes included.
- R5: With both enables set and both polarity bits 0, the main pin follows the reference and the complementary pin follows its inverse. A forced reference leaves the two pins in opposite states: forced high gives main 1 and complementary 0.
- R6: With dead time D and both pins enabled, a pin turns on D+1 clocks after the reference edge that activates it and turns off 1 clock after the edge that deactivates it. The two pins are never active at the same time.
- R7: When D is at least as long as a reference pulse, the pin that pulse would activate stays inactive for the whole pulse. Per period of P+1 clocks with compare C (1..P), the main pin is active for max(0, C−D) clocks and the complementary pin for max(0, P+1−C−D) clocks.
- R8: An enabled pin outputs its active state XOR its polarity bit. Polarity 1 inverts the pin.
- R9: When exactly one pin of the pair is enabled, that pin outputs the reference delayed by one clock. It is not inverted and has no dead time.
- R10: A disabled pin has output-enable 0 if control bit 4 (off-state drive) is 0. If that bit is 1, the pin has output-enable 1 and drives its inactive level, which is equal to its polarity bit.
- R11: After reset the counter, period, compare, mode, dead time and control are all 0. Both output-enables are 0, both pins are 0 and `oc_ref` is 0.
- R12: Register writes take effect at the clock edge where `wr_en` is 1. The addresses are 0 for period, 1 for compare, 2 for mode (bits 2:0), 3 for control and 4 for dead time. The control register bits are: 0 main enable, 1 complementary enable, 2 main polarity, 3 complementary polarity, 4 off-state drive, 5 run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data; DATA_W is the largest of CNT_W, DT_W and 8 |
| cnt_value | output | CNT_W | Current counter value |
| oc_ref | output | 1 | Internal active-high reference waveform |
| cmp_match | output | 1 | Counter equals compare value |
| main_out | output | 1 | Main pin level |
| main_oe | output | 1 | Main pin output-enable |
| comp_out | output | 1 | Complementary pin level |
| comp_oe | output | 1 | Complementary pin output-enable |

## Verification
A wrong counter or compare state shows at once on `cnt_value`, `oc_ref` and `cmp_match`, because these are sampled every clock against an arithmetic model of the count. A fault in the dead-time countdown or the edge tracking does not show on the reference. It shows as a wrong number of active clocks per period on one of the pins, so it is caught within one period after settling, across a sweep of compare values and dead times. Enable, polarity and off-state faults show on the pin and output-enable levels one clock after the control write that selects them.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam logic [2:0] ADDR_PERIOD  = 3'd0;
  localparam logic [2:0] ADDR_COMPARE = 3'd1;
  localparam logic [2:0] ADDR_MODE    = 3'd2;
  localparam logic [2:0] ADDR_CTRL    = 3'd3;
  localparam logic [2:0] ADDR_DEAD    = 3'd4;

  localparam logic [2:0] MODE_FORCE_LO = 3'b100;
  localparam logic [2:0] MODE_FORCE_HI = 3'b101;
  localparam logic [2:0] MODE_PWM_LOW  = 3'b110;

  // control word, MSB first: run is bit 5, main enable is bit 0
  typedef struct packed {
    logic run;
    logic off_drive;
    logic comp_pol;
    logic main_pol;
    logic comp_en;
    logic main_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [2:0]        mode_q,
  output ctrl_t             ctrl_q,
  output logic [DT_W-1:0]   dt_q
);

  logic [CNT_W-1:0] period_n;
  logic [CNT_W-1:0] cmp_n;
  logic [2:0]       mode_n;
  ctrl_t            ctrl_n;
  logic [DT_W-1:0]  dt_n;
  logic             unused_data;

  assign unused_data = ^wr_data;

  always_comb begin
    period_n = period_q;
    cmp_n    = cmp_q;
    mode_n   = mode_q;
    ctrl_n   = ctrl_q;
    dt_n     = dt_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_PERIOD:  period_n = wr_data[CNT_W-1:0];
        ADDR_COMPARE: cmp_n    = wr_data[CNT_W-1:0];
        ADDR_MODE:    mode_n   = wr_data[2:0];
        ADDR_CTRL:    ctrl_n   = ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_DEAD:    dt_n     = wr_data[DT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cmp_q    <= '0;
      mode_q   <= '0;
      ctrl_q   <= '0;
      dt_q     <= '0;
    end else begin
      period_q <= period_n;
      cmp_q    <= cmp_n;
      mode_q   <= mode_n;
      ctrl_q   <= ctrl_n;
      dt_q     <= dt_n;
    end
  end

  AST_WRITE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL) |=> (ctrl_q == ctrl_t'($past(wr_data[CTRL_W-1:0])))); // R12

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  input  logic [2:0]       mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             oc_ref,
  output logic             match
);

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (run) begin
      cnt_n = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_comb begin
    unique case (mode)
      MODE_FORCE_HI: oc_ref = 1'b1;
      MODE_PWM_LOW:  oc_ref = (cnt_q < cmp);
      default:       oc_ref = 1'b0;
    endcase
  end

  assign match = (cnt_q == cmp);

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q >= period) |=> (cnt_q == '0)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q < period) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oc_ref,
  input  logic [DT_W-1:0] dt,
  output logic            ref_q,
  output logic            dir_q,
  output logic            inv_q
);

  logic [DT_W-1:0] dt_cnt_q;
  logic [DT_W-1:0] dt_cnt_n;
  logic [DT_W-1:0] remain;
  logic            ref_edge;
  logic            settled;
  logic            dir_n;
  logic            inv_n;

  always_comb begin
    ref_edge = oc_ref ^ ref_q;
    remain   = ref_edge ? dt : dt_cnt_q;
    settled  = (remain == '0);
    dt_cnt_n = settled ? '0 : remain - 1'b1;
    dir_n    = oc_ref & settled;
    inv_n    = ~oc_ref & settled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      dt_cnt_q <= '0;
      dir_q    <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      ref_q    <= oc_ref;
      dt_cnt_q <= dt_cnt_n;
      dir_q    <= dir_n;
      inv_q    <= inv_n;
    end
  end

  AST_DT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_cnt_q != '0) |-> (!dir_q && !inv_q)); // R7
  AST_DIR_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_ref && ref_q) |=> !dir_q); // R6
  AST_INV_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_ref && !ref_q) |=> !inv_q); // R6

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage (
  input  logic en,
  input  logic peer_en,
  input  logic pol,
  input  logic off_drive,
  input  logic paired,
  input  logic solo,
  output logic pin,
  output logic oe
);

  logic active;

  always_comb begin
    active = peer_en ? paired : solo;
    if (en) begin
      oe  = 1'b1;
      pin = active ^ pol;
    end else begin
      oe  = off_drive;
      pin = pol;
    end
  end

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8,
  localparam int WIDE_W = (CNT_W > DT_W) ? CNT_W : DT_W,
  localparam int DATA_W = (WIDE_W > 8) ? WIDE_W : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              oc_ref,
  output logic              cmp_match,
  output logic              main_out,
  output logic              main_oe,
  output logic              comp_out,
  output logic              comp_oe
);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cmp_q;
  logic [2:0]       mode_q;
  ctrl_t            ctrl_q;
  logic [DT_W-1:0]  dt_q;
  logic             ref_q;
  logic             dir_q;
  logic             inv_q;

  cpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_q (period_q),
    .cmp_q    (cmp_q),
    .mode_q   (mode_q),
    .ctrl_q   (ctrl_q),
    .dt_q     (dt_q)
  );

  cpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.run),
    .period (period_q),
    .cmp    (cmp_q),
    .mode   (mode_q),
    .cnt_q  (cnt_value),
    .oc_ref (oc_ref),
    .match  (cmp_match)
  );

  cpwm_deadtime #(.DT_W(DT_W)) u_deadtime (
    .clk    (clk),
    .rst_n  (rst_n),
    .oc_ref (oc_ref),
    .dt     (dt_q),
    .ref_q  (ref_q),
    .dir_q  (dir_q),
    .inv_q  (inv_q)
  );

  cpwm_outstage u_main (
    .en        (ctrl_q.main_en),
    .peer_en   (ctrl_q.comp_en),
    .pol       (ctrl_q.main_pol),
    .off_drive (ctrl_q.off_drive),
    .paired    (dir_q),
    .solo      (ref_q),
    .pin       (main_out),
    .oe        (main_oe)
  );

  cpwm_outstage u_comp (
    .en        (ctrl_q.comp_en),
    .peer_en   (ctrl_q.main_en),
    .pol       (ctrl_q.comp_pol),
    .off_drive (ctrl_q.off_drive),
    .paired    (inv_q),
    .solo      (ref_q),
    .pin       (comp_out),
    .oe        (comp_oe)
  );

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.main_en && ctrl_q.comp_en) |->
      !((main_out ^ ctrl_q.main_pol) && (comp_out ^ ctrl_q.comp_pol))); // R6
  AST_MAIN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.main_en && !ctrl_q.off_drive) |-> !main_oe); // R10
  AST_COMP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.comp_en && !ctrl_q.off_drive) |-> !comp_oe); // R10
  AST_MAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.main_en && ctrl_q.off_drive) |-> (main_oe && main_out == ctrl_q.main_pol)); // R10
  AST_SOLO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.comp_en && !ctrl_q.main_en && $stable(ctrl_q)) |->
      (comp_out == ($past(oc_ref) ^ ctrl_q.comp_pol))); // R9

endmodule

// File: tb/test_cpwm_channel.sv
`timescale 1ns/1ps
module test_cpwm_channel;

  localparam int CNT_W = 6;
  localparam int DT_W  = 4;
  localparam int A_PER = 0, A_CMP = 1, A_MODE = 2, A_CTRL = 3, A_DT = 4;
  localparam int B_MEN = 1, B_CEN = 2, B_MPOL = 4, B_CPOL = 8, B_OFFD = 16, B_RUN = 32;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [2:0]       wr_addr;
  logic [7:0]       wr_data;
  logic [CNT_W-1:0] cnt_value;
  logic             oc_ref, cmp_match, main_out, main_oe, comp_out, comp_oe;

  int tests, fails, cyc;
  bit done;
  int m_cnt, m_per, m_cmp, m_run;
  bit p_valid;
  int p_addr, p_data;

  cpwm_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) i_cpwm_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_value(cnt_value), .oc_ref(oc_ref), .cmp_match(cmp_match),
    .main_out(main_out), .main_oe(main_oe), .comp_out(comp_out), .comp_oe(comp_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: model counter uses the configuration in force before the edge (R1)
  task automatic step();
    @(posedge clk);
    if (m_run != 0) m_cnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
    if (p_valid) begin
      case (p_addr)
        A_PER:  m_per = p_data;
        A_CMP:  m_cmp = p_data;
        A_CTRL: m_run = (p_data >> 5) & 1;
        default: ;
      endcase
      p_valid = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[7:0];
    p_valid = 1'b1;
    p_addr  = a;
    p_data  = d;
    step();
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int hm, hc, both, first_on, em, ec;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_cnt = 0; m_per = 0; m_cmp = 0; m_run = 0; p_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 cnt", cnt_value, 0);
    chk("R11 main_oe", main_oe, 0);
    chk("R11 comp_oe", comp_oe, 0);
    chk("R11 main_out", main_out, 0);
    chk("R11 comp_out", comp_out, 0);
    chk("R11 oc_ref", oc_ref, 0);
    chk("R4 match at reset", cmp_match, 1);

    // R1 counting and wrap
    wr(A_PER, 5);
    wr(A_CTRL, B_RUN);
    chk("R12 run bit takes effect at write edge", cnt_value, 0);
    step();
    chk("R12 counter moves one clock later", cnt_value, 1);
    for (int i = 0; i < 14; i++) begin
      step();
      chk("R1 count", cnt_value, m_cnt);
    end
    wr(A_CTRL, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R1 hold when stopped", cnt_value, m_cnt);
    end

    // R2 / R4 sweep of compare over small periods
    wr(A_MODE, 6);
    wr(A_CTRL, B_RUN);
    for (int p = 4; p <= 6; p += 2) begin
      for (int c = 0; c <= p + 2; c++) begin
        wr(A_PER, p);
        wr(A_CMP, c);
        for (int i = 0; i < 2 * (p + 1); i++) begin
          step();
          chk("R1 count", cnt_value, m_cnt);
          chk("R2 pwm reference", oc_ref, (m_cnt < m_cmp) ? 1 : 0);
          chk("R4 match", cmp_match, (m_cnt == m_cmp) ? 1 : 0);
        end
      end
    end

    // R3 forced and other modes; R4 match keeps running
    wr(A_PER, 5);
    wr(A_CMP, 2);
    for (int md = 0; md < 8; md++) begin
      if (md == 6) continue;
      wr(A_MODE, md);
      for (int i = 0; i < 8; i++) begin
        step();
        chk("R3 forced reference", oc_ref, (md == 5) ? 1 : 0);
        chk("R4 match while forced", cmp_match, (m_cnt == m_cmp) ? 1 : 0);
      end
    end

    // R6 / R7 dead-time sweep, both pins enabled
    wr(A_MODE, 6);
    wr(A_CTRL, B_RUN | B_MEN | B_CEN);
    for (int d = 0; d <= 3; d++) begin
      for (int c = 1; c <= 7; c++) begin
        wr(A_PER, 7);
        wr(A_CMP, c);
        wr(A_DT, d);
        settle(16);
        hm = 0; hc = 0; both = 0;
        for (int i = 0; i < 8; i++) begin
          step();
          hm += main_out;
          hc += comp_out;
          if (main_out && comp_out) both++;
        end
        em = (c > d) ? c - d : 0;
        ec = ((8 - c) > d) ? 8 - c - d : 0;
        chk("R7 main active clocks", hm, em);
        chk("R7 comp active clocks", hc, ec);
        chk("R6 never both active", both, 0);
      end
    end

    // R5 / R6 forced pair and edge delays
    wr(A_DT, 3);
    wr(A_MODE, 4);
    settle(8);
    chk("R5 forced low main", main_out, 0);
    chk("R5 forced low comp", comp_out, 1);
    wr(A_MODE, 5);
    chk("R6 main still off at write", main_out, 0);
    chk("R6 comp still on at write", comp_out, 1);
    first_on = 0;
    for (int k = 1; k <= 8; k++) begin
      step();
      if (k == 1) chk("R6 comp off after one clock", comp_out, 0);
      if (main_out && first_on == 0) first_on = k;
    end
    chk("R6 main turn-on delay", first_on, 4);
    chk("R5 forced high main", main_out, 1);
    chk("R5 forced high comp", comp_out, 0);

    // R8 polarity
    wr(A_CTRL, B_RUN | B_MEN | B_CEN | B_MPOL | B_CPOL);
    step();
    chk("R8 main inverted", main_out, 0);
    chk("R8 comp inverted", comp_out, 1);
    wr(A_MODE, 4);
    settle(8);
    chk("R8 main inverted low", main_out, 1);
    chk("R8 comp inverted low", comp_out, 0);

    // R9 single pin enabled
    wr(A_CTRL, B_RUN | B_CEN);
    settle(6);
    chk("R9 comp copies low reference", comp_out, 0);
    chk("R10 main floats", main_oe, 0);
    wr(A_MODE, 5);
    chk("R9 comp before delay", comp_out, 0);
    step();
    chk("R9 comp follows without dead time", comp_out, 1);
    wr(A_CTRL, B_RUN | B_MEN);
    wr(A_MODE, 4);
    chk("R9 main before delay", main_out, 1);
    step();
    chk("R9 main follows without dead time", main_out, 0);
    chk("R10 comp floats", comp_oe, 0);

    // R10 off-state drive
    wr(A_CTRL, B_RUN | B_CEN | B_OFFD | B_MPOL);
    chk("R10 main driven", main_oe, 1);
    chk("R10 main inactive level pol1", main_out, 1);
    wr(A_CTRL, B_RUN | B_CEN | B_OFFD);
    chk("R10 main inactive level pol0", main_out, 0);
    chk("R10 main still driven", main_oe, 1);
    wr(A_CTRL, B_RUN | B_MEN | B_OFFD | B_CPOL);
    chk("R10 comp driven", comp_oe, 1);
    chk("R10 comp inactive level pol1", comp_out, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule